// File: doc/BRIEF.md
# Key-Locked Oscillator Control Register

This block holds the divider settings of a programmable clock synthesizer in a small word-addressed register file. The file has two locations. One is a key register. The other is a configuration word that is guarded by that key. Software opens the guard by writing a 16-bit key value to the key register, changes the configuration word, and then closes the guard again by writing any other value. While the guard is closed, the configuration word ignores every write.

A build-time parameter selects one of six field layouts for the configuration word. Each layout fixes which bits of the word are writable and how the feedback divider (v), reference divider (r) and output divider select (s) are taken from those bits. Some layouts expose only part of a field and tie the rest to constants. One layout uses a single bit to choose between two fixed divider triples. The decoded v, r and s values appear on output ports for the synthesizer next to the block. Reads are combinational from the address.

Top module: `osc_cfg_regblk`

## Requirements
- R1: After reset the guard is closed, so a read of the key register (word address 1) returns 0. The configuration word (word address 0) holds the parameter RESET_CFG ANDed with the layout's write mask.
- R2: A write of exactly 0x0000A05F to the key register opens the guard. While the guard is open, a read of the key register returns 1 in bit 0 and 0 in all other bits.
- R3: A write to the key register of any value other than 0x0000A05F closes the guard. This includes 0, and it includes 0x0001A05F.
- R4: A write to the configuration word while the guard is closed has no effect.
- R5: A write to the configuration word while the guard is open replaces only the bits under the layout's mask. Bits outside the mask always read 0.
- R6: Full layout (LAY_FULL): mask 0x7FFFF. v is bits 8:0, r is bits 15:9 and s is bits 18:16.
- R7: First narrow layout (LAY_NARROW_A): mask 0xFF. v is bits 7:0 with its bit 8 reading 0. r is fixed at 22 and s is fixed at 1.
- R8: Second narrow layout (LAY_NARROW_B): the same as R7, except that r is fixed at 46 and s is fixed at 3.
- R9: Core layout (LAY_CORE): mask 0x7FF. v is bits 7:0 and s is bits 10:8. r is fixed at 22.
- R10: Memory layout (LAY_MEM): mask 0x7FF000. v is bits 19:12 and s is bits 22:20. r is fixed at 22.
- R11: Preset layout (LAY_PRESET): mask 0x100. When bit 8 is 1 the outputs are v=17, r=22, s=1. When bit 8 is 0 the outputs are v=14, r=14, s=1.
- R12: Writes to the configuration word and to unmapped addresses leave the guard state unchanged.
- R13: A read of an unmapped address returns 0. A write to an unmapped address changes neither the guard nor the configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| v_out | output | 9 | Decoded feedback divider |
| r_out | output | 7 | Decoded reference divider |
| s_out | output | 3 | Decoded output divider select |

## Verification
The same write patterns go to all six layouts at once, so one data word shows how each mask and decode treats the same bits. An alternating pattern (0x5A5A5A5A) tells apart fields that are placed correctly from fields that are shifted or swapped. An all-ones word shows that each mask stops at its edge and that the tied bit 8 of v stays at 0. A lone bit 8 flips the preset layout between its two triples. Key values that come close to the real key (one extra upper bit set, 0, or written to an unmapped address) are each followed by a configuration write that must be dropped. This shows that the guard compares the full word and responds only at its own address.

// File: rtl/osc_cfg_pkg.sv
package osc_cfg_pkg;

  typedef enum logic [2:0] {
    LAY_FULL     = 3'd0,
    LAY_NARROW_A = 3'd1,
    LAY_NARROW_B = 3'd2,
    LAY_CORE     = 3'd3,
    LAY_MEM      = 3'd4,
    LAY_PRESET   = 3'd5
  } layout_e;

  localparam int V_W = 9;
  localparam int R_W = 7;
  localparam int S_W = 3;

  // Writable bits of the configuration word for each layout
  function automatic logic [31:0] layout_mask(layout_e lay);
    case (lay)
      LAY_FULL:     return 32'h0007_FFFF;
      LAY_NARROW_A: return 32'h0000_00FF;
      LAY_NARROW_B: return 32'h0000_00FF;
      LAY_CORE:     return 32'h0000_07FF;
      LAY_MEM:      return 32'h007F_F000;
      LAY_PRESET:   return 32'h0000_0100;
      default:      return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/osc_reset_sync.sv
module osc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/osc_lock_unit.sv
module osc_lock_unit #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = 32'h0000_A05F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              open_q
);
  logic open_d;
  logic open_en;

  always_comb begin
    open_en = key_wr;
    open_d  = (wdata == KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       open_q <= 1'b0;
    else if (open_en) open_q <= open_d;
  end
endmodule

// File: rtl/osc_cfg_store.sv
module osc_cfg_store #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] MASK = '1,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cfg_q
);
  localparam logic [DATA_W-1:0] RST_MASKED = RESET_VAL & MASK;

  logic [DATA_W-1:0] cfg_d;
  logic              cfg_en;

  always_comb begin
    cfg_en = cfg_wr;
    cfg_d  = (wdata & MASK) | (cfg_q & ~MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= RST_MASKED;
    else if (cfg_en) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/osc_field_decode.sv
module osc_field_decode
  import osc_cfg_pkg::*;
#(
  parameter int      DATA_W = 32,
  parameter layout_e LAYOUT = LAY_FULL
) (
  input  logic [DATA_W-1:0] cfg,
  output logic [V_W-1:0]    v_out,
  output logic [R_W-1:0]    r_out,
  output logic [S_W-1:0]    s_out
);
  generate
    case (LAYOUT)
      LAY_FULL: begin : g_full
        assign v_out = cfg[8:0];
        assign r_out = cfg[15:9];
        assign s_out = cfg[18:16];
      end
      LAY_NARROW_A: begin : g_narrow_a
        assign v_out = {1'b0, cfg[7:0]};
        assign r_out = R_W'(22);
        assign s_out = S_W'(1);
      end
      LAY_NARROW_B: begin : g_narrow_b
        assign v_out = {1'b0, cfg[7:0]};
        assign r_out = R_W'(46);
        assign s_out = S_W'(3);
      end
      LAY_CORE: begin : g_core
        assign v_out = {1'b0, cfg[7:0]};
        assign r_out = R_W'(22);
        assign s_out = cfg[10:8];
      end
      LAY_MEM: begin : g_mem
        assign v_out = {1'b0, cfg[19:12]};
        assign r_out = R_W'(22);
        assign s_out = cfg[22:20];
      end
      default: begin : g_preset
        assign v_out = cfg[8] ? V_W'(17) : V_W'(14);
        assign r_out = cfg[8] ? R_W'(22) : R_W'(14);
        assign s_out = S_W'(1);
      end
    endcase
  endgenerate
endmodule

// File: rtl/osc_cfg_regblk.sv
module osc_cfg_regblk
  import osc_cfg_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                ADDR_W    = 4,
  parameter layout_e           LAYOUT    = LAY_FULL,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 4'd0,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 4'd1,
  parameter logic [DATA_W-1:0] KEY       = 32'h0000_A05F,
  parameter logic [DATA_W-1:0] RESET_CFG = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [V_W-1:0]    v_out,
  output logic [R_W-1:0]    r_out,
  output logic [S_W-1:0]    s_out
);
  localparam logic [DATA_W-1:0] MASK = DATA_W'(layout_mask(LAYOUT));

  logic              rst_sn;
  logic              lock_q;
  logic [DATA_W-1:0] cfg_q;
  logic              key_wr;
  logic              cfg_wr;

  osc_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  always_comb begin
    key_wr = bus_we && (bus_addr == LOCK_ADDR);
    cfg_wr = bus_we && (bus_addr == CFG_ADDR) && lock_q;
  end

  osc_lock_unit #(.DATA_W(DATA_W), .KEY(KEY)) u_lock (
    .clk(clk), .rst_n(rst_sn), .key_wr(key_wr),
    .wdata(bus_wdata), .open_q(lock_q)
  );

  osc_cfg_store #(.DATA_W(DATA_W), .MASK(MASK), .RESET_VAL(RESET_CFG)) u_store (
    .clk(clk), .rst_n(rst_sn), .cfg_wr(cfg_wr),
    .wdata(bus_wdata), .cfg_q(cfg_q)
  );

  osc_field_decode #(.DATA_W(DATA_W), .LAYOUT(LAYOUT)) u_dec (
    .cfg(cfg_q), .v_out(v_out), .r_out(r_out), .s_out(s_out)
  );

  always_comb begin
    if (bus_addr == CFG_ADDR)       bus_rdata = cfg_q;
    else if (bus_addr == LOCK_ADDR) bus_rdata = DATA_W'(lock_q);
    else                            bus_rdata = '0;
  end
endmodule

// File: rtl/osc_cfg_chk.sv
module osc_cfg_chk
  import osc_cfg_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                ADDR_W    = 4,
  parameter layout_e           LAYOUT    = LAY_FULL,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 4'd0,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 4'd1,
  parameter logic [DATA_W-1:0] KEY       = 32'h0000_A05F
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              lock_q,
  input logic [DATA_W-1:0] cfg_q,
  input logic [V_W-1:0]    v_out,
  input logic [R_W-1:0]    r_out,
  input logic [S_W-1:0]    s_out
);
  localparam logic [DATA_W-1:0] CMASK = DATA_W'(layout_mask(LAYOUT));

  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == LOCK_ADDR && bus_wdata == KEY) |=> lock_q); // R2
  AST_OTHER_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == LOCK_ADDR && bus_wdata != KEY) |=> !lock_q); // R3
  AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q |=> $stable(cfg_q)); // R4
  AST_OUTSIDE_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q & ~CMASK) == '0); // R5
  AST_GUARD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == LOCK_ADDR) |=> $stable(lock_q)); // R12
  AST_UNMAPPED_NO_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != CFG_ADDR) |=> $stable(cfg_q)); // R13

  generate
    if (LAYOUT == LAY_NARROW_A) begin : g_a
      AST_NARROW_A_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        r_out == 7'd22 && s_out == 3'd1 && !v_out[8]); // R7
    end else if (LAYOUT == LAY_NARROW_B) begin : g_b
      AST_NARROW_B_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        r_out == 7'd46 && s_out == 3'd3 && !v_out[8]); // R8
    end else if (LAYOUT == LAY_CORE) begin : g_c
      AST_CORE_R_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        r_out == 7'd22 && !v_out[8]); // R9
    end else if (LAYOUT == LAY_MEM) begin : g_m
      AST_MEM_R_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        r_out == 7'd22 && !v_out[8]); // R10
    end else if (LAYOUT == LAY_PRESET) begin : g_p
      AST_PRESET_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        s_out == 3'd1 && ((v_out == 9'd17 && r_out == 7'd22) ||
                          (v_out == 9'd14 && r_out == 7'd14))); // R11
    end
  endgenerate
endmodule

bind osc_cfg_regblk osc_cfg_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LAYOUT(LAYOUT),
  .CFG_ADDR(CFG_ADDR), .LOCK_ADDR(LOCK_ADDR), .KEY(KEY)
) u_chk (
  .clk(clk), .rst_n(rst_sn), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .lock_q(lock_q), .cfg_q(cfg_q),
  .v_out(v_out), .r_out(r_out), .s_out(s_out)
);

// File: tb/sim_osc_cfg_regblk.sv
`timescale 1ns/1ps
module sim_osc_cfg_regblk;
  import osc_cfg_pkg::*;

  localparam int NL = 6;
  localparam logic [3:0] A_CFG  = 4'd0;
  localparam logic [3:0] A_LOCK = 4'd1;
  localparam logic [3:0] A_NONE = 4'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdat [NL];
  logic [8:0]  vo [NL];
  logic [6:0]  ro [NL];
  logic [2:0]  so [NL];
  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  function automatic layout_e lay_of(int i);
    return layout_e'(i);
  endfunction

  osc_cfg_regblk #(.LAYOUT(LAY_FULL), .RESET_CFG(32'hFFF8_1234)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdat[0]), .v_out(vo[0]), .r_out(ro[0]), .s_out(so[0]));

  for (genvar i = 1; i < NL; i++) begin : g_lay
    osc_cfg_regblk #(.LAYOUT(lay_of(i))) u_lay (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
      .bus_rdata(rdat[i]), .v_out(vo[i]), .r_out(ro[i]), .s_out(so[i]));
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic sel(input logic [3:0] a);
    addr = a;
    #1;
  endtask

  task automatic chk_fields(input string tag, input int i,
                            input logic [8:0] v, input logic [6:0] r, input logic [2:0] s);
    chk({tag, " v"}, 32'(vo[i]), 32'(v));
    chk({tag, " r"}, 32'(ro[i]), 32'(r));
    chk({tag, " s"}, 32'(so[i]), 32'(s));
  endtask

  task automatic t_reset;
    sel(A_LOCK);
    chk("R1 lock closed", rdat[0], 32'h0);
    sel(A_CFG);
    chk("R1 reset cfg masked", rdat[0], 32'h0000_1234);
    chk_fields("R1 full reset", 0, 9'h034, 7'h09, 3'd0);
    chk_fields("R1 narrowA reset", 1, 9'd0, 7'd22, 3'd1);
    chk_fields("R1 preset reset", 5, 9'd14, 7'd14, 3'd1);
  endtask

  task automatic t_locked_drop;
    wr(A_CFG, 32'hFFFF_FFFF);
    sel(A_CFG);
    chk("R4 locked write dropped", rdat[0], 32'h0000_1234);
    chk("R4 locked mem unchanged", rdat[4], 32'h0);
  endtask

  task automatic t_unmapped;
    wr(A_NONE, 32'h0000_A05F);
    sel(A_LOCK);
    chk("R13 key at unmapped addr", rdat[0], 32'h0);
    sel(A_NONE);
    chk("R13 unmapped reads 0", rdat[0], 32'h0);
  endtask

  task automatic t_unlock;
    wr(A_LOCK, 32'h0000_A05F);
    sel(A_LOCK);
    chk("R2 lock open", rdat[0], 32'h1);
  endtask

  task automatic t_pattern;
    wr(A_CFG, 32'h5A5A_5A5A);
    sel(A_CFG);
    chk("R5 full masked", rdat[0], 32'h0002_5A5A);
    chk_fields("R6 full", 0, 9'h05A, 7'h2D, 3'd2);
    chk("R5 narrowA masked", rdat[1], 32'h0000_005A);
    chk_fields("R7 narrowA", 1, 9'h05A, 7'd22, 3'd1);
    chk_fields("R8 narrowB", 2, 9'h05A, 7'd46, 3'd3);
    chk("R5 core masked", rdat[3], 32'h0000_025A);
    chk_fields("R9 core", 3, 9'h05A, 7'd22, 3'd2);
    chk("R5 mem masked", rdat[4], 32'h005A_5000);
    chk_fields("R10 mem", 4, 9'h0A5, 7'd22, 3'd5);
    chk_fields("R11 preset bit0", 5, 9'd14, 7'd14, 3'd1);
    sel(A_LOCK);
    chk("R12 open after cfg write", rdat[0], 32'h1);
    sel(A_NONE);
    wr(A_NONE, 32'h0);
    sel(A_LOCK);
    chk("R12 open after unmapped write", rdat[0], 32'h1);
  endtask

  task automatic t_bit8;
    wr(A_CFG, 32'h0000_0100);
    chk_fields("R11 preset bit1", 5, 9'd17, 7'd22, 3'd1);
    chk_fields("R6 full v bit8", 0, 9'h100, 7'd0, 3'd0);
    chk_fields("R7 narrowA v bit8 zero", 1, 9'd0, 7'd22, 3'd1);
    chk_fields("R9 core s from bit8", 3, 9'd0, 7'd22, 3'd1);
  endtask

  task automatic t_ones;
    wr(A_CFG, 32'hFFFF_FFFF);
    sel(A_CFG);
    chk("R5 full ones", rdat[0], 32'h0007_FFFF);
    chk_fields("R6 full ones", 0, 9'h1FF, 7'h7F, 3'd7);
    chk_fields("R7 narrowA ones", 1, 9'h0FF, 7'd22, 3'd1);
    chk_fields("R8 narrowB ones", 2, 9'h0FF, 7'd46, 3'd3);
    chk_fields("R9 core ones", 3, 9'h0FF, 7'd22, 3'd7);
    chk("R5 mem ones", rdat[4], 32'h007F_F000);
    chk_fields("R10 mem ones", 4, 9'h0FF, 7'd22, 3'd7);
    chk("R5 preset ones", rdat[5], 32'h0000_0100);
  endtask

  task automatic t_close;
    wr(A_LOCK, 32'h0000_1234);
    sel(A_LOCK);
    chk("R3 other value closes", rdat[0], 32'h0);
    wr(A_CFG, 32'h0);
    sel(A_CFG);
    chk("R4 dropped after close", rdat[0], 32'h0007_FFFF);
    wr(A_LOCK, 32'h0000_A05F);
    wr(A_LOCK, 32'h0);
    sel(A_LOCK);
    chk("R3 zero closes", rdat[0], 32'h0);
    wr(A_LOCK, 32'h0001_A05F);
    sel(A_LOCK);
    chk("R3 near key stays closed", rdat[0], 32'h0);
    wr(A_CFG, 32'h0);
    chk_fields("R4 preset kept", 5, 9'd17, 7'd22, 3'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_locked_drop();
    t_unmapped();
    t_unlock();
    t_pattern();
    t_bit8();
    t_ones();
    t_close();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL R1-watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule